// File: doc/BRIEF.md
# Opcode Loader Timing Sequencer

This block sits between an instruction prefetch queue and the opcode decode stage. It takes the next opcode byte from the queue into an instruction register and produces two timing strobes. The first-cycle strobe marks the cycle in which the opcode byte is taken. The second-cycle strobe marks the following cycle, in which the external decode flags for that byte are valid. From those flags the loader picks one of four paths:
- a hardwired one-byte instruction (a prefix counts as one) moves straight on to the next opcode;
- an instruction that needs a second decode byte consumes that byte and holds off microcode for one cycle;
- any other instruction starts microcode;
- a halt stops all queue traffic until an external resume.

While microcode runs, the loader watches the "one cycle remaining" indication. When that indication is present, the loader fetches the next opcode in the same cycle, so the two instructions overlap. If the queue is empty at any point where a byte is needed, the loader waits for one.

Top module: `insn_loader`

## Requirements
- R1: `fc` is high exactly when the loader is ready for a new opcode and `q_valid` is high. The loader is ready when it is idle, or when it is in a microcode cycle with `uc_last` high. `pop_first` and `ir_load` equal `fc`.
- R2: When the loader is ready but `q_valid` is low, `fc` stays low and the loader keeps waiting, with no pop.
- R3: `sc` is high in the cycle after `fc`. It is held off while the decoded instruction needs a second byte and `q_valid` is low. `sc`, `uc_start` and `uc_block` are never high together.
- R4: A hardwired one-byte instruction (`dec_one_byte` or `dec_prefix` high at `sc`) gives no `uc_start` and no `uc_block`. The next `fc` can come in the cycle right after `sc`, so two instructions are never less than two cycles apart.
- R5: An instruction with `dec_second_byte` high at `sc` (and no higher-priority flag) raises `pop_second` in the same cycle as `sc`.
- R6: After a two-byte `sc`, `uc_block` is high for exactly the next cycle, and `uc_start` is high in the cycle after that.
- R7: An instruction with none of the four decode flags set raises `uc_start` in the cycle after `sc`.
- R8: In a microcode cycle (the `uc_start` cycle or a later one), `uc_last` together with `q_valid` gives `fc` in that same cycle. `uc_last` without `q_valid` returns the loader to idle waiting.
- R9: `dec_halt` at `sc` takes priority over every other flag. From the next cycle on there is no `fc`, `pop_first` or `pop_second` until a cycle with `resume` high. After that cycle the loader is idle and ready. `resume` has no effect in any other state.
- R10: While `rst` is high, the next clock edge puts the loader in idle and clears `ir_byte`. `ir_byte` takes `q_byte` at each `fc` and holds it otherwise. Decode-flag priority is halt, then one-byte/prefix, then second-byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| q_valid | input | 1 | Prefetch queue holds at least one byte |
| q_byte | input | BYTE_W | Byte at the head of the queue |
| dec_one_byte | input | 1 | Decode: hardwired one-byte instruction |
| dec_second_byte | input | 1 | Decode: a second decode byte is required |
| dec_prefix | input | 1 | Decode: prefix byte |
| dec_halt | input | 1 | Decode: halt instruction |
| uc_last | input | 1 | Microcode reports one cycle remaining |
| resume | input | 1 | Leave the halted state |
| fc | output | 1 | First-cycle strobe |
| sc | output | 1 | Second-cycle strobe |
| ir_load | output | 1 | Instruction register load |
| ir_byte | output | BYTE_W | Instruction register contents |
| pop_first | output | 1 | Queue pop for the opcode byte |
| pop_second | output | 1 | Queue pop for the second decode byte |
| uc_start | output | 1 | Start the microcode routine |
| uc_block | output | 1 | Hold microcode off for one cycle |

## Verification
The assertions check several properties on every cycle:
- two `fc` strobes never come back to back;
- `pop_second` only occurs with `sc`, and is always followed by one `uc_block` cycle and then `uc_start`;
- the phase strobes are mutually exclusive;
- nothing is popped while halted;
- the instruction register changes only on a load.

Other behaviour can only be shown by the bench's pseudo-random sweep against its own cycle model:
- the exact cycle in which `fc` overlaps the last microcode cycle;
- stalls of `fc` and `sc` on an empty queue;
- the priority among decode flags;
- that `resume` is ignored outside the halted state.

// File: rtl/ldr_pkg.sv
package ldr_pkg;

  typedef enum logic [2:0] {
    LS_IDLE   = 3'd0,
    LS_SC     = 3'd1,
    LS_UBLK   = 3'd2,
    LS_USTART = 3'd3,
    LS_UEXEC  = 3'd4,
    LS_HALT   = 3'd5
  } ldr_state_e;

  typedef enum logic [1:0] {
    K_MICRO = 2'd0,
    K_ONE   = 2'd1,
    K_TWO   = 2'd2,
    K_HALT  = 2'd3
  } ldr_kind_e;

endpackage

// File: rtl/ldr_classify.sv
module ldr_classify
  import ldr_pkg::*;
(
  input  logic      one_byte,
  input  logic      second_byte,
  input  logic      prefix,
  input  logic      halt,
  output ldr_kind_e kind
);

  // Priority: halt, then hardwired one-byte (prefixes included), then two-byte.
  always_comb begin
    if (halt)                  kind = K_HALT;
    else if (one_byte | prefix) kind = K_ONE;
    else if (second_byte)       kind = K_TWO;
    else                        kind = K_MICRO;
  end

endmodule

// File: rtl/ldr_ir.sv
module ldr_ir #(
  parameter int          BYTE_W    = 8,
  parameter logic [BYTE_W-1:0] RESET_VAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] dout
);

  always_ff @(posedge clk) begin
    if (rst)       dout <= RESET_VAL;
    else if (load) dout <= din;
  end

endmodule

// File: rtl/ldr_fsm.sv
module ldr_fsm
  import ldr_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      q_valid,
  input  ldr_kind_e kind,
  input  logic      uc_last,
  input  logic      resume,
  output logic      fc,
  output logic      sc,
  output logic      pop_second,
  output logic      uc_start,
  output logic      uc_block
);

  ldr_state_e state, state_nx;
  logic in_ucode, ready, two_byte;

  assign in_ucode   = (state == LS_USTART) || (state == LS_UEXEC);
  assign ready      = (state == LS_IDLE) || (in_ucode && uc_last);
  assign two_byte   = (kind == K_TWO);
  assign fc         = ready && q_valid;
  assign sc         = (state == LS_SC) && (!two_byte || q_valid);
  assign pop_second = sc && two_byte;
  assign uc_start   = (state == LS_USTART);
  assign uc_block   = (state == LS_UBLK);

  always_comb begin
    state_nx = state;
    unique case (state)
      LS_IDLE: if (fc) state_nx = LS_SC;
      LS_SC: begin
        if (sc) begin
          unique case (kind)
            K_HALT:  state_nx = LS_HALT;
            K_ONE:   state_nx = LS_IDLE;
            K_TWO:   state_nx = LS_UBLK;
            default: state_nx = LS_USTART;
          endcase
        end
      end
      LS_UBLK: state_nx = LS_USTART;
      LS_USTART, LS_UEXEC: begin
        if (fc)           state_nx = LS_SC;
        else if (uc_last) state_nx = LS_IDLE;
        else              state_nx = LS_UEXEC;
      end
      LS_HALT: if (resume) state_nx = LS_IDLE;
      default: state_nx = LS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= LS_IDLE;
    else     state <= state_nx;
  end

  // R4: no two opcode fetches in consecutive cycles
  a_r4_min_two_clocks: assert property (@(posedge clk) disable iff (rst)
    fc |=> !fc);
  // R5: second byte is consumed only in the second-cycle phase
  a_r5_pop2_with_sc: assert property (@(posedge clk) disable iff (rst)
    pop_second |-> sc);
  // R6: block follows the second-byte pop, start follows the block
  a_r6_block_after_pop2: assert property (@(posedge clk) disable iff (rst)
    pop_second |=> uc_block);
  a_r6_start_after_block: assert property (@(posedge clk) disable iff (rst)
    uc_block |=> uc_start);
  // R3: phase strobes are mutually exclusive
  a_r3_phase_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sc, uc_start, uc_block}));
  // R9: no queue traffic while halted
  a_r9_halt_no_pop: assert property (@(posedge clk) disable iff (rst)
    (state == LS_HALT) |-> (!fc && !pop_second));

endmodule

// File: rtl/insn_loader.sv
module insn_loader
  import ldr_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              q_valid,
  input  logic [BYTE_W-1:0] q_byte,
  input  logic              dec_one_byte,
  input  logic              dec_second_byte,
  input  logic              dec_prefix,
  input  logic              dec_halt,
  input  logic              uc_last,
  input  logic              resume,
  output logic              fc,
  output logic              sc,
  output logic              ir_load,
  output logic [BYTE_W-1:0] ir_byte,
  output logic              pop_first,
  output logic              pop_second,
  output logic              uc_start,
  output logic              uc_block
);

  ldr_kind_e kind;
  logic      fc_w;

  ldr_classify u_cls (
    .one_byte    (dec_one_byte),
    .second_byte (dec_second_byte),
    .prefix      (dec_prefix),
    .halt        (dec_halt),
    .kind        (kind)
  );

  ldr_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .q_valid    (q_valid),
    .kind       (kind),
    .uc_last    (uc_last),
    .resume     (resume),
    .fc         (fc_w),
    .sc         (sc),
    .pop_second (pop_second),
    .uc_start   (uc_start),
    .uc_block   (uc_block)
  );

  ldr_ir #(.BYTE_W(BYTE_W), .RESET_VAL('0)) u_ir (
    .clk  (clk),
    .rst  (rst),
    .load (fc_w),
    .din  (q_byte),
    .dout (ir_byte)
  );

  assign fc        = fc_w;
  assign ir_load   = fc_w;
  assign pop_first = fc_w;

  // R10: instruction register only changes on a load
  a_r10_ir_hold: assert property (@(posedge clk) disable iff (rst)
    !ir_load |=> $stable(ir_byte));

endmodule

// File: tb/insn_loader_tb.sv
module insn_loader_tb_top;

  localparam int CLK_P  = 10;
  localparam int BYTE_W = 8;
  localparam int NCYC   = 6000;

  localparam int M_IDLE = 0, M_SC = 1, M_BLK = 2, M_UST = 3, M_UEX = 4, M_HALT = 5;

  logic clk = 1'b0;
  logic rst;
  logic q_valid, dec_one_byte, dec_second_byte, dec_prefix, dec_halt, uc_last, resume;
  logic [BYTE_W-1:0] q_byte;
  logic fc, sc, ir_load, pop_first, pop_second, uc_start, uc_block;
  logic [BYTE_W-1:0] ir_byte;

  int tests = 0;
  int fails = 0;
  int mst;
  logic [BYTE_W-1:0] m_ir;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_P/2) clk = ~clk;

  insn_loader #(.BYTE_W(BYTE_W)) dut_i (
    .clk(clk), .rst(rst), .q_valid(q_valid), .q_byte(q_byte),
    .dec_one_byte(dec_one_byte), .dec_second_byte(dec_second_byte),
    .dec_prefix(dec_prefix), .dec_halt(dec_halt), .uc_last(uc_last),
    .resume(resume), .fc(fc), .sc(sc), .ir_load(ir_load), .ir_byte(ir_byte),
    .pop_first(pop_first), .pop_second(pop_second),
    .uc_start(uc_start), .uc_block(uc_block)
  );

  task automatic chk(input string req, input string nm, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d (t=%0t)", req, nm, act, exp, $time);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; q_valid = 0; q_byte = '0; dec_one_byte = 0; dec_second_byte = 0;
    dec_prefix = 0; dec_halt = 0; uc_last = 0; resume = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R10: reset state, idle with empty queue means every strobe low
    chk("R10", "fc",       fc,       0);
    chk("R10", "sc",       sc,       0);
    chk("R10", "uc_start", uc_start, 0);
    chk("R10", "uc_block", uc_block, 0);
    chk("R10", "ir_byte",  ir_byte,  0);
    mst  = M_IDLE;
    m_ir = '0;

    for (int cyc = 0; cyc < NCYC; cyc++) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rst             = (cyc % 1500) == 1499;
      q_valid         = lfsr[0] | lfsr[1];
      dec_one_byte    = lfsr[2] & lfsr[3];
      dec_prefix      = lfsr[4] & lfsr[5] & lfsr[6];
      dec_second_byte = lfsr[7];
      dec_halt        = lfsr[8] & lfsr[9] & lfsr[10] & lfsr[11];
      uc_last         = lfsr[12];
      resume          = lfsr[13] & lfsr[14];
      q_byte          = BYTE_W'(cyc * 7 + 3);
      #1;
      begin
        bit rdy, e_fc, e_sc, e_p2, n2, one;
        int nx;
        one  = dec_one_byte | dec_prefix;
        n2   = dec_second_byte & !dec_halt & !one;
        rdy  = (mst == M_IDLE) || ((mst == M_UST || mst == M_UEX) && uc_last);
        e_fc = rdy && q_valid;
        e_sc = (mst == M_SC) && (!n2 || q_valid);
        e_p2 = e_sc && n2;
        chk("R1", "fc",        fc,        e_fc);
        chk("R1", "pop_first", pop_first, e_fc);
        chk("R1", "ir_load",   ir_load,   e_fc);
        chk("R3", "sc",        sc,        e_sc);
        chk("R5", "pop_second", pop_second, e_p2);
        chk("R6", "uc_block",  uc_block,  mst == M_BLK);
        chk("R7", "uc_start",  uc_start,  mst == M_UST);
        chk("R10", "ir_byte",  ir_byte,   m_ir);
        if (mst == M_HALT)
          chk("R9", "halt_pops", fc | pop_second, 0);
        if (rdy && !q_valid)
          chk("R2", "stall_fc", fc, 0);
        nx = mst;
        case (mst)
          M_IDLE: if (e_fc) nx = M_SC;
          M_SC: if (e_sc) begin
            if (dec_halt) nx = M_HALT;        // R9 priority
            else if (one) nx = M_IDLE;        // R4
            else if (n2)  nx = M_BLK;         // R6
            else          nx = M_UST;         // R7
          end
          M_BLK: nx = M_UST;
          M_UST, M_UEX: nx = e_fc ? M_SC : (uc_last ? M_IDLE : M_UEX); // R8
          M_HALT: if (resume) nx = M_IDLE;
          default: nx = M_IDLE;
        endcase
        if (e_fc) m_ir = q_byte;
        if (rst) begin
          nx   = M_IDLE;
          m_ir = '0;
        end
        mst = nx;
      end
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule